// File: doc/BRIEF.md
# Three-Wire Serial Configuration Slave

This block is the slave side of a serial configuration port. It has a chip select, a serial clock and one shared data line. Its logic runs on a fast system clock. All three pins are resynchronized and the serial clock is edge-detected. Because of this, the serial clock may run at any rate well below the system clock.

A frame opens with a five-bit command. A data phase follows the command. Command bit 4 chooses a write (1) or a read (0). Command bit 3 chooses the frame type:

- **Short frame (0):** `NORM_BITS` data bits, one serial clock per bit.
- **Long frame (1):** `EXT_BITS` data bits, `EXT_DIV` serial clocks per bit.

On a write, the block shifts the data in and gives the register back end one strobe with the finished word. On a read, the block asks the back end for a word. It then takes the data line over after the last command bit and shifts the word out, most significant bit first. When chip select is low, the whole interface is held in reset. This also returns the data line to high impedance.

In long frames the back end also sees a sub-phase count. The count runs through the serial clock periods inside each data bit. A frame that stops short produces no strobe. Clocks after a frame ends have no effect.

Top module: `cfg3w_slave`

## Requirements
- R1: After system reset, and from at most three system clocks after chip select goes low, `sdio_oe`, `wr_strobe` and `cmd_valid` are 0 and `sub_phase` is 0.
- R2: The command is taken from `sdio_in` on five rising serial-clock edges, bit 4 first. After the fifth edge, `cmd_valid` pulses for exactly one system clock, and `cmd_o` holds the command until chip select falls.
- R3: `cmd_o[4]`=1 marks a write and `cmd_o[4]`=0 marks a read. `cmd_o[3]`=1 selects a long frame (`EXT_BITS` bits, `EXT_DIV` clocks each). `cmd_o[3]`=0 selects a short frame (`NORM_BITS` bits, one clock each).
- R4: In a short write, data bits are sampled MSB first, one per rising edge. After the last edge, `wr_strobe` pulses once. At that pulse, `wr_data` holds the word in bits `[NORM_BITS-1:0]`, and all bits above are 0.
- R5: In a long write, each data bit is sampled on the first of its `EXT_DIV` rising edges, MSB first. `wr_strobe` pulses once, after the last clock of the last bit. At that pulse, `wr_data` holds all `EXT_BITS` bits.
- R6: In a read, `sdio_oe` rises only after `cmd_valid`. The MSB of `rd_data` (bit `NORM_BITS-1` or bit `EXT_BITS-1`) is presented first. The next bit follows after each data bit's first rising edge, so bit k is valid before the first edge of data bit k.
- R7: In a long frame's data phase, before the j-th data rising edge (counting from 0), `sub_phase` equals j mod `EXT_DIV`. In short frames, `sub_phase` stays 0.
- R8: `sdio_oe` is never 1 while the captured command is a write. It returns to 0 within three system clocks of chip select going low.
- R9: If chip select falls before a write frame's last data clock, no `wr_strobe` is produced.
- R10: Serial clocks beyond a frame's length cause no second `wr_strobe`, and they leave `wr_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csel_in | input | 1 | Chip select from the pad; high marks an access |
| sclk_in | input | 1 | Serial clock from the pad |
| sdio_in | input | 1 | Data line value from the pad |
| sdio_out | output | 1 | Read data bit driven onto the pad |
| sdio_oe | output | 1 | Pad output enable for the data line |
| cmd_o | output | CMD_BITS | Captured command |
| cmd_valid | output | 1 | One-cycle pulse when the command is complete |
| rd_data | input | EXT_BITS | Read word from the back end, sampled during `cmd_valid` |
| wr_data | output | EXT_BITS | Received write word |
| wr_strobe | output | 1 | One-cycle pulse when a complete write frame has arrived |
| sub_phase | output | $clog2(EXT_DIV) | Serial clock index within the current long-frame data bit |

## Verification
The bench builds the block with `NORM_BITS`=6, `EXT_BITS`=10 and `EXT_DIV`=4, with a serial clock half-period of six system clocks. These short frame lengths make it affordable to send every one of the 32 command codes, each with two data patterns. That covers both directions and both frame types, with every read bit and every sub-phase value checked at the pins. The same small lengths leave room for frames cut off mid-data and frames padded with surplus clocks, in both frame types.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    // Sequencer phases of one access.
    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_LOAD = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    // Pad-side lines that cross into the system clock domain.
    typedef struct packed {
        logic cs;
        logic sclk;
        logic dio;
    } pad_lines_t;

    // Number of data bits in a frame of the chosen type.
    function automatic int unsigned frame_bits(input logic long_frame,
                                               input int unsigned short_n,
                                               input int unsigned long_n);
        return long_frame ? long_n : short_n;
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // One independent flop chain per line.
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/cfg3w_seq.sv
module cfg3w_seq
    import cfg3w_pkg::*;
#(
    parameter int NORM_BITS = 16,
    parameter int EXT_BITS  = 46,
    parameter int EXT_DIV   = 4,
    parameter int CMD_BITS  = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs,
    input  logic                        rise,
    input  logic                        dio,
    output logic [CMD_BITS-1:0]         cmd,
    output logic                        cmd_valid,
    output logic                        bit_step,
    output logic                        frame_end,
    output logic                        oe,
    output logic [$clog2(EXT_DIV)-1:0]  sub
);
    localparam int SW = $clog2(EXT_DIV);
    localparam int CW = $clog2(CMD_BITS);
    localparam int BW = $clog2(EXT_BITS + 1);

    seq_state_t    state;
    logic [CW-1:0] ccnt;
    logic [BW-1:0] bcnt;
    logic          is_wr, is_ext, slot_end, last_bit;

    assign is_wr    = cmd[CMD_BITS-1];
    assign is_ext   = cmd[CMD_BITS-2];
    assign slot_end = !is_ext || (sub == SW'(EXT_DIV - 1));
    assign last_bit = (bcnt == BW'(frame_bits(is_ext, NORM_BITS, EXT_BITS) - 1));

    assign cmd_valid = (state == ST_LOAD);
    assign bit_step  = (state == ST_DATA) && rise && (sub == '0);
    assign frame_end = (state == ST_DATA) && rise && slot_end && last_bit;

    always_ff @(posedge clk) begin
        if (rst || !cs) begin
            state <= ST_CMD;
            cmd   <= '0;
            ccnt  <= '0;
            bcnt  <= '0;
            sub   <= '0;
            oe    <= 1'b0;
        end else begin
            case (state)
                ST_CMD: if (rise) begin
                    cmd <= {cmd[CMD_BITS-2:0], dio};
                    if (ccnt == CW'(CMD_BITS - 1)) state <= ST_LOAD;
                    else                           ccnt  <= ccnt + 1'b1;
                end
                ST_LOAD: begin
                    state <= ST_DATA;
                    oe    <= !is_wr;
                end
                ST_DATA: if (rise) begin
                    if (slot_end) begin
                        sub <= '0;
                        if (last_bit) state <= ST_DONE;
                        else          bcnt  <= bcnt + 1'b1;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg3w_shreg.sv
module cfg3w_shreg #(
    parameter int NORM_BITS = 16,
    parameter int EXT_BITS  = 46
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                load,
    input  logic                step,
    input  logic                long_frame,
    input  logic                din,
    input  logic [EXT_BITS-1:0] par_in,
    output logic [EXT_BITS-1:0] par_out,
    output logic                dout
);
    logic [EXT_BITS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst || clear) sr <= '0;
        else if (load)    sr <= par_in;
        else if (step)    sr <= {sr[EXT_BITS-2:0], din};
    end

    assign par_out = sr;
    assign dout    = long_frame ? sr[EXT_BITS-1] : sr[NORM_BITS-1];
endmodule

// File: rtl/cfg3w_slave.sv
module cfg3w_slave
    import cfg3w_pkg::*;
#(
    parameter int NORM_BITS   = 16,
    parameter int EXT_BITS    = 46,
    parameter int EXT_DIV     = 4,
    parameter int CMD_BITS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        csel_in,
    input  logic                        sclk_in,
    input  logic                        sdio_in,
    output logic                        sdio_out,
    output logic                        sdio_oe,
    output logic [CMD_BITS-1:0]         cmd_o,
    output logic                        cmd_valid,
    input  logic [EXT_BITS-1:0]         rd_data,
    output logic [EXT_BITS-1:0]         wr_data,
    output logic                        wr_strobe,
    output logic [$clog2(EXT_DIV)-1:0]  sub_phase
);
    pad_lines_t raw, syn;
    logic       sclk_d, rise;
    logic       bit_step, frame_end, oe_q, strobe_q;

    assign raw = '{cs: csel_in, sclk: sclk_in, dio: sdio_in};

    cfg3w_sync #(.WIDTH($bits(pad_lines_t)), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= syn.sclk;
    end
    assign rise = syn.sclk && !sclk_d;

    cfg3w_seq #(
        .NORM_BITS(NORM_BITS), .EXT_BITS(EXT_BITS),
        .EXT_DIV(EXT_DIV), .CMD_BITS(CMD_BITS)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .cs        (syn.cs),
        .rise      (rise),
        .dio       (syn.dio),
        .cmd       (cmd_o),
        .cmd_valid (cmd_valid),
        .bit_step  (bit_step),
        .frame_end (frame_end),
        .oe        (oe_q),
        .sub       (sub_phase)
    );

    cfg3w_shreg #(.NORM_BITS(NORM_BITS), .EXT_BITS(EXT_BITS)) shreg_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (!syn.cs),
        .load       (cmd_valid && !cmd_o[CMD_BITS-1]),
        .step       (bit_step),
        .long_frame (cmd_o[CMD_BITS-2]),
        .din        (syn.dio),
        .par_in     (rd_data),
        .par_out    (wr_data),
        .dout       (sdio_out)
    );

    // Strobe is registered so it meets the word after its final shift.
    always_ff @(posedge clk) begin
        if (rst || !syn.cs) strobe_q <= 1'b0;
        else                strobe_q <= frame_end && cmd_o[CMD_BITS-1];
    end

    assign wr_strobe = strobe_q;
    assign sdio_oe   = oe_q;
endmodule

// File: rtl/cfg3w_slave_chk.sv
module cfg3w_slave_chk #(
    parameter int NORM_BITS   = 16,
    parameter int EXT_BITS    = 46,
    parameter int EXT_DIV     = 4,
    parameter int CMD_BITS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        csel_in,
    input logic                        sclk_in,
    input logic                        sdio_in,
    input logic                        sdio_out,
    input logic                        sdio_oe,
    input logic [CMD_BITS-1:0]         cmd_o,
    input logic                        cmd_valid,
    input logic [EXT_BITS-1:0]         rd_data,
    input logic [EXT_BITS-1:0]         wr_data,
    input logic                        wr_strobe,
    input logic [$clog2(EXT_DIV)-1:0]  sub_phase
);
    // R1: a chip select held low for three cycles silences the block
    a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        (!csel_in && $past(!csel_in) && $past(!csel_in, 2) && $past(!csel_in, 3))
        |-> (!sdio_oe && !wr_strobe && !cmd_valid));

    // R2: command completion is a single-cycle pulse
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R4: write strobe is a single-cycle pulse and only for writes
    a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);
    a_r4_strobe_on_write: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> cmd_o[CMD_BITS-1]);

    // R6: the pin is taken over only after the command completed
    a_r6_drive_after_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(sdio_oe) |-> $past(cmd_valid));

    // R7: sub-phase moves only in long frames and stays in range
    a_r7_sub_long_only: assert property (@(posedge clk) disable iff (rst)
        (sub_phase != '0) |-> (cmd_o[CMD_BITS-2] && (int'(sub_phase) < EXT_DIV)));

    // R8: the pin is never driven during a write
    a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> !cmd_o[CMD_BITS-1]);
endmodule

bind cfg3w_slave cfg3w_slave_chk #(
    .NORM_BITS(NORM_BITS), .EXT_BITS(EXT_BITS), .EXT_DIV(EXT_DIV),
    .CMD_BITS(CMD_BITS), .SYNC_STAGES(SYNC_STAGES)
) chk_i (.*);

// File: tb/cfg3w_slave_tb.sv
module cfg3w_slave_tb_top;
    localparam int NB  = 6;
    localparam int EB  = 10;
    localparam int DIV = 4;
    localparam int SW  = $clog2(DIV);
    localparam int H   = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          csel, sclk, sdin;
    logic          sdout, sdoe, cmd_valid, wr_strobe;
    logic [4:0]    cmd_o;
    logic [EB-1:0] rd_data, wr_data;
    logic [SW-1:0] sub_phase;

    int n_checks = 0;
    int n_errors = 0;
    int n_strobe = 0;
    int n_valid  = 0;
    int cyc      = 0;
    logic [EB-1:0] cap_wr;
    logic [4:0]    cap_cmd;

    always #2.5 clk = ~clk;

    cfg3w_slave #(.NORM_BITS(NB), .EXT_BITS(EB), .EXT_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .csel_in(csel), .sclk_in(sclk), .sdio_in(sdin),
        .sdio_out(sdout), .sdio_oe(sdoe), .cmd_o(cmd_o), .cmd_valid(cmd_valid),
        .rd_data(rd_data), .wr_data(wr_data), .wr_strobe(wr_strobe),
        .sub_phase(sub_phase)
    );

    // Back-end model: a read word derived from the command code.
    function automatic logic [EB-1:0] rd_model(input logic [4:0] c);
        return EB'((32'(c) * 32'd40503 + 32'd777) >> 3);
    endfunction
    assign rd_data = rd_model(cmd_o);

    function automatic logic [EB-1:0] wr_pattern(input logic [4:0] c, input int p);
        return EB'((32'(c) * 32'd97 + 32'(p) * 32'd613 + 32'd5) ^ 32'h2A5);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && wr_strobe) begin n_strobe <= n_strobe + 1; cap_wr <= wr_data; end
        if (!rst && cmd_valid) begin n_valid <= n_valid + 1; cap_cmd <= cmd_o; end
        if (cyc == 150000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One access: command, data phase (minus cut, plus extra clocks), deselect.
    task automatic run_frame(input logic [4:0] c, input logic [EB-1:0] wd,
                             input int extra, input int cut);
        bit is_wr  = c[4];
        bit is_ext = c[3];
        int nbits  = is_ext ? EB : NB;
        int div    = is_ext ? DIV : 1;
        int total  = nbits * div;
        int s0     = n_strobe;
        int v0     = n_valid;
        logic [EB-1:0] exp_rd = rd_model(c);
        logic [EB-1:0] exp_wr = '0;
        csel = 1'b1;
        wait_clk(H);
        for (int i = 4; i >= 0; i--) begin
            sdin = c[i];
            wait_clk(H);
            if (i == 4) chk(sdoe == 1'b0, "R6 idle before command", 64'(sdoe), 0);
            sclk = 1'b1; wait_clk(H); sclk = 1'b0;
        end
        sdin = 1'b0;
        for (int r = 0; r < total + extra - cut; r++) begin
            int k = r / div;
            if (is_wr && r < total) sdin = wd[nbits-1-k];
            else                    sdin = 1'b0;
            wait_clk(H);
            if (r < total) begin
                // R7: sub-phase before this data edge
                chk(sub_phase == SW'(r % div), "R7 sub-phase", 64'(sub_phase), 64'(r % div));
                if (!is_wr && (r % div) == 0) begin
                    chk(sdoe == 1'b1, "R6 read drive", 64'(sdoe), 1);
                    chk(sdout == exp_rd[nbits-1-k], "R6 read bit", 64'(sdout), 64'(exp_rd[nbits-1-k]));
                end
                if (is_wr) chk(sdoe == 1'b0, "R8 no drive on write", 64'(sdoe), 0);
            end
            sclk = 1'b1; wait_clk(H); sclk = 1'b0;
        end
        wait_clk(H);
        chk(n_valid - v0 == 1 && cap_cmd == c, "R2 command capture", 64'(cap_cmd), 64'(c));
        chk(cmd_o[4] == c[4] && cmd_o[3] == c[3], "R3 mode bits", 64'(cmd_o), 64'(c));
        csel = 1'b0;
        wait_clk(4);
        chk(sdoe == 1'b0, "R8 release after deselect", 64'(sdoe), 0);
        chk(sub_phase == '0 && !cmd_valid, "R1 deselected state", 64'(sub_phase), 0);
        for (int b = 0; b < nbits; b++) exp_wr[b] = wd[b];
        if (is_wr && cut == 0) begin
            chk(n_strobe - s0 == 1, is_ext ? "R5 single strobe" : "R4 single strobe",
                64'(n_strobe - s0), 1);
            chk(cap_wr == exp_wr, is_ext ? "R5 long write word" : "R4 short write word",
                64'(cap_wr), 64'(exp_wr));
            if (extra > 0)
                chk(n_strobe - s0 == 1 && cap_wr == exp_wr, "R10 surplus clocks ignored",
                    64'(cap_wr), 64'(exp_wr));
        end else begin
            chk(n_strobe - s0 == 0, is_wr ? "R9 cut write discarded" : "R3 read gives no strobe",
                64'(n_strobe - s0), 0);
        end
        wait_clk(H);
    endtask

    initial begin
        rst = 1'b1; csel = 1'b0; sclk = 1'b0; sdin = 1'b0;
        wait_clk(6);
        rst = 1'b0;
        wait_clk(4);
        chk(!sdoe && !wr_strobe && !cmd_valid && sub_phase == '0, "R1 reset state",
            64'({sdoe, wr_strobe, cmd_valid}), 0);
        for (int c = 0; c < 32; c++)
            for (int p = 0; p < 2; p++)
                run_frame(5'(c), wr_pattern(5'(c), p), 0, 0);
        // R9: frames cut short in both frame types
        run_frame(5'b10010, wr_pattern(5'd2, 3), 0, 1);
        run_frame(5'b11001, wr_pattern(5'd9, 4), 0, 3);
        run_frame(5'b11100, wr_pattern(5'd4, 5), 0, 21);
        // R10: surplus clocks after the frame
        run_frame(5'b10101, wr_pattern(5'd5, 6), 7, 0);
        run_frame(5'b11110, wr_pattern(5'd6, 7), 9, 0);
        run_frame(5'b01011, '0, 5, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule